// File: doc/BRIEF.md
# Extended Integer Execute Stage

This block is the arithmetic stage of a 32-bit core that finishes each instruction in one clock cycle. It receives up to three source register values, the 5-bit shift-count field of the instruction, a sign-extended immediate, an operand select and an operation code. It produces a result word, a zero flag and a signed-overflow flag. Register read, decode and memory access sit outside the block.

It covers the usual integer set: add, subtract, AND, OR, signed set-less-than and arithmetic right shift. It also has two extra operations. The first is a three-source add, in which an auxiliary adder sums the first two sources and the main adder then adds the third, all in the same cycle. The second is a single-bit set: a shifter turns a bit position into a one-hot mask, and the mask is ORed into a target value. All outputs are registered, so they appear one clock edge after the inputs are presented.

Top module: `exec_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled edge, `res` is 0, `zf` is 1 and `of` is 0.
- R2: Outputs are registered. Inputs sampled at a rising edge of `clk` show on the outputs just after that edge and stay there until the next edge.
- R3: Op code 3'b000 is add and 3'b001 is subtract (`src_a` minus operand B). Operand B is `src_b` when `use_imm` is 0 and `imm` when it is 1.
- R4: Op code 3'b010 is bitwise AND and 3'b011 is bitwise OR of `src_a` with the same operand B.
- R5: Op code 3'b100 gives 1 when `src_a` is less than operand B, both taken as signed numbers, and 0 otherwise.
- R6: Op code 3'b101 shifts `src_b` right arithmetically, copying bit 31 into the vacated bits. The shift count is `shamt` when `amt_from_reg` is 0 and `src_a[4:0]` when it is 1.
- R7: Op code 3'b110 gives `src_a + src_b + src_c` modulo 2^32. `use_imm` has no effect on it.
- R8: Op code 3'b111 gives `src_b` with bit `src_a[4:0]` forced to 1. Bits 31:5 of `src_a` have no effect.
- R9: `of` is 1 for add, subtract and three-source add when the exact signed result falls outside [-2^31, 2^31-1]. It is 0 for every other op code. An intermediate carry that the third source cancels does not set it.
- R10: `zf` is 1 exactly when the registered 32-bit result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Operation code |
| src_a | input | 32 | First source register value; also the bit position / shift count source |
| src_b | input | 32 | Second source register value; shift value and bit-set target |
| src_c | input | 32 | Third source register value, used only by three-source add |
| shamt | input | 5 | Shift count field from the instruction |
| imm | input | 32 | Sign-extended immediate |
| use_imm | input | 1 | Selects `imm` instead of `src_b` as operand B |
| amt_from_reg | input | 1 | Takes the right-shift count from `src_a[4:0]` instead of `shamt` |
| res | output | 32 | Registered result |
| zf | output | 1 | Registered zero flag |
| of | output | 1 | Registered signed-overflow flag |

## Verification
The hardest case is the three-source add near the edges of the signed range. Here the partial sum from the auxiliary adder wraps while the final sum fits, or both partial sums fit while the total does not. Random operands almost never land on these cases, so the stimulus uses directed triples built around 0x7FFFFFFF, 0x80000000 and 0x40000000, with the exact sum worked out in 64-bit integers. The bit-set and shift-count paths get source values whose upper bits are deliberately noisy, so that only the low five bits can select the result.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_SLT  = 3'b100,
        OP_SRA  = 3'b101,
        OP_ADD3 = 3'b110,
        OP_BSET = 3'b111
    } exu_op_e;
endpackage

// File: rtl/exu_sra.sv
// Arithmetic right shifter with its own count-source mux (R6).
module exu_sra #(
    parameter int W  = 32,
    localparam int SH = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  logic [SH-1:0] field_amt,
    input  logic [SH-1:0] reg_amt,
    input  logic          amt_sel,
    output logic [W-1:0]  shifted
);
    logic [SH-1:0] amt;
    logic [W-1:0]  stage [SH+1];

    always_comb amt = amt_sel ? reg_amt : field_amt;

    assign stage[0] = value;
    // One log2 stage per bit of the count, sign bit fills from the left.
    for (genvar s = 0; s < SH; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {{D{stage[s][W-1]}}, stage[s][W-1:D]} : stage[s];
    end
    assign shifted = stage[SH];
endmodule

// File: rtl/exu_bitmask.sv
// One-hot mask generator for the bit-set operation (R8).
module exu_bitmask #(
    parameter int W  = 32,
    localparam int SH = $clog2(W)
) (
    input  logic [SH-1:0] pos,
    output logic [W-1:0]  mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (pos == SH'(i));
    end

    always_comb begin
        AST_MASK_ONEHOT: assert ($countones(mask) == 1); // R8
    end
endmodule

// File: rtl/exu_aux_add.sv
// Auxiliary adder: sign-extended partial sum of the first two sources (R7).
module exu_aux_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   partial
);
    always_comb partial = {a[W-1], a} + {b[W-1], b};
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int SH = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [W-1:0]  src_c,
    input  logic [SH-1:0] shamt,
    input  logic [W-1:0]  imm,
    input  logic          use_imm,
    input  logic          amt_from_reg,
    output logic [W-1:0]  res,
    output logic          zf,
    output logic          of
);
    typedef struct packed {
        logic [W-1:0] result;
        logic         zero;
        logic         ovf;
    } exu_state_t;

    exu_state_t st_d, st_q;

    logic [W-1:0] opb;
    logic [W-1:0] sra_out;
    logic [W-1:0] bit_mask;
    logic [W:0]   pair_sum;
    logic [W:0]   sum_w;
    logic [W:0]   dif_w;
    logic [W+1:0] tri_w;

    exu_sra #(.W(W)) u_sra (
        .value    (src_b),
        .field_amt(shamt),
        .reg_amt  (src_a[SH-1:0]),
        .amt_sel  (amt_from_reg),
        .shifted  (sra_out)
    );

    exu_bitmask #(.W(W)) u_mask (
        .pos (src_a[SH-1:0]),
        .mask(bit_mask)
    );

    exu_aux_add #(.W(W)) u_aux (
        .a      (src_a),
        .b      (src_b),
        .partial(pair_sum)
    );

    always_comb begin
        opb   = use_imm ? imm : src_b;
        sum_w = {src_a[W-1], src_a} + {opb[W-1], opb};
        dif_w = {src_a[W-1], src_a} - {opb[W-1], opb};
        tri_w = {pair_sum[W], pair_sum} + {{2{src_c[W-1]}}, src_c};

        st_d = '0;
        unique case (exu_op_e'(op))
            OP_ADD: begin
                st_d.result = sum_w[W-1:0];
                st_d.ovf    = sum_w[W] ^ sum_w[W-1];
            end
            OP_SUB: begin
                st_d.result = dif_w[W-1:0];
                st_d.ovf    = dif_w[W] ^ dif_w[W-1];
            end
            OP_AND:  st_d.result = src_a & opb;
            OP_OR:   st_d.result = src_a | opb;
            OP_SLT:  st_d.result = {{(W-1){1'b0}}, ($signed(src_a) < $signed(opb))};
            OP_SRA:  st_d.result = sra_out;
            OP_ADD3: begin
                st_d.result = tri_w[W-1:0];
                st_d.ovf    = !((tri_w[W+1:W-1] == 3'b000) || (tri_w[W+1:W-1] == 3'b111));
            end
            OP_BSET: st_d.result = src_b | bit_mask;
            default: st_d.result = '0;
        endcase
        st_d.zero = (st_d.result == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{result: '0, zero: 1'b1, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.result;
    assign zf  = st_q.zero;
    assign of  = st_q.ovf;

    AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) inside {3'b010, 3'b011, 3'b100, 3'b101, 3'b111})) |-> !of); // R9

    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b100) |-> (res[W-1:1] == '0)); // R5

    AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b101) |-> (res[W-1] == $past(src_b[W-1]))); // R6

    AST_BSET_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b111) |-> ((res & $past(src_b)) == $past(src_b))); // R8

    AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 3'b001 && !$past(use_imm) && $past(src_a) == $past(src_b))
        |-> (zf && !of)); // R3
endmodule

// File: tb/exec_unit_test.sv
module exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0, imm = '0;
    logic [4:0]  shamt = '0;
    logic        use_imm = 1'b0, amt_from_reg = 1'b0;
    logic [31:0] res;
    logic        zf, of;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .shamt(shamt), .imm(imm), .use_imm(use_imm),
        .amt_from_reg(amt_from_reg), .res(res), .zf(zf), .of(of)
    );

    function automatic longint sx(input logic [31:0] v);
        return longint'($signed(v));
    endfunction

    // Behavioural reference: {result, zero, ovf}
    function automatic logic [33:0] model(input logic [2:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] c, input logic [4:0] sh,
            input logic [31:0] im, input logic ui, input logic ar);
        longint exact;
        logic [31:0] ob, r;
        logic ov;
        int cnt;
        ob = ui ? im : b;
        ov = 1'b0;
        exact = 0;
        case (o)
            3'd0: begin exact = sx(a) + sx(ob); r = exact[31:0]; end
            3'd1: begin exact = sx(a) - sx(ob); r = exact[31:0]; end
            3'd2: r = a & ob;
            3'd3: r = a | ob;
            3'd4: r = (sx(a) < sx(ob)) ? 32'd1 : 32'd0;
            3'd5: begin
                cnt = ar ? int'(a[4:0]) : int'(sh);
                exact = sx(b) / (longint'(1) << cnt);
                if (sx(b) < 0 && (sx(b) % (longint'(1) << cnt)) != 0) exact = exact - 1;
                r = exact[31:0];
            end
            3'd6: begin exact = sx(a) + sx(b) + sx(c); r = exact[31:0]; end
            default: begin
                r = b;
                r[a[4:0]] = 1'b1;
            end
        endcase
        if (o == 3'd0 || o == 3'd1 || o == 3'd6)
            ov = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
        return {r, (r == 32'd0), ov};
    endfunction

    task automatic check(input string tag, input logic [33:0] exp);
        n_tests++;
        if ({res, zf, of} !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h zf=%b of=%b, expected res=%h zf=%b of=%b",
                     tag, res, zf, of, exp[33:2], exp[1], exp[0]);
        end
    endtask

    // Drive at negedge, one register on the way: check just after the next posedge.
    task automatic run(input string tag, input logic [2:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] c, input logic [4:0] sh,
            input logic [31:0] im, input logic ui, input logic ar);
        logic [33:0] exp;
        @(negedge clk);
        op = o; src_a = a; src_b = b; src_c = c; shamt = sh; imm = im;
        use_imm = ui; amt_from_reg = ar;
        exp = model(o, a, b, c, sh, im, ui, ar);
        @(posedge clk); #1;
        check(tag, exp);
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        op = 3'd0; src_a = 32'd5; src_b = 32'd7;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", {32'd0, 1'b1, 1'b0});
        @(negedge clk); rst_n = 1'b1;

        // R3: add / sub with register and immediate operand B
        run("R3 add reg",   3'd0, 32'd100, 32'd23, 32'd0, 5'd0, 32'hDEAD_BEEF, 1'b0, 1'b0);
        run("R3 add imm",   3'd0, 32'd100, 32'hFFFF_0000, 32'd0, 5'd0, 32'hFFFF_FFF6, 1'b1, 1'b0);
        run("R3 sub reg",   3'd1, 32'd5, 32'd9, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R3 sub imm",   3'd1, 32'd50, 32'd1, 32'd0, 5'd0, 32'd8, 1'b1, 1'b0);

        // R2: latency - new inputs must not reach outputs before the edge
        @(negedge clk);
        op = 3'd0; src_a = 32'd1; src_b = 32'd1; use_imm = 1'b0;
        #1 check("R2 hold before edge", {32'd42, 1'b0, 1'b0});
        @(posedge clk); #1;
        check("R2 after edge", {32'd2, 1'b0, 1'b0});

        // R4: logic ops
        run("R4 and reg", 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R4 or imm",  3'd3, 32'h0000_00F0, 32'hFFFF_FFFF, 32'd0, 5'd0, 32'h0000_0F0F, 1'b1, 1'b0);

        // R5: signed compare
        run("R5 slt neg<pos", 3'd4, 32'hFFFF_FFFF, 32'd1, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R5 slt pos>neg", 3'd4, 32'd5, 32'd0, 32'd0, 5'd0, 32'hFFFF_FFFD, 1'b1, 1'b0);
        run("R5 slt equal",   3'd4, 32'd7, 32'd7, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);

        // R6: arithmetic right shift, both count sources
        run("R6 sra field",     3'd5, 32'hFFFF_FF00, 32'h8000_0000, 32'd0, 5'd4, 32'd0, 1'b0, 1'b0);
        run("R6 sra reg low5",  3'd5, 32'hABCD_EF23, 32'h0000_0F00, 32'd0, 5'd0, 32'd0, 1'b0, 1'b1);
        run("R6 sra 31 neg",    3'd5, 32'd0, 32'h9000_0001, 32'd0, 5'd31, 32'd0, 1'b0, 1'b0);
        run("R6 sra 0",         3'd5, 32'd0, 32'hC000_0003, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);

        // R7: three-source add, use_imm ignored
        run("R7 add3",          3'd6, 32'd10, 32'd20, 32'd30, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R7 add3 imm ign",  3'd6, 32'd1, 32'hFFFF_FFFE, 32'd4, 5'd0, 32'd999, 1'b1, 1'b0);

        // R8: bit set, upper position bits ignored
        run("R8 bset low5",     3'd7, 32'hFFFF_FFE5, 32'd0, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R8 bset already",  3'd7, 32'd3, 32'h0000_0008, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R8 bset bit31",    3'd7, 32'h0000_07FF, 32'h0000_0001, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);

        // R9: overflow detection
        run("R9 add ovf",           3'd0, 32'h7FFF_FFFF, 32'd1, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R9 sub ovf",           3'd1, 32'h8000_0000, 32'd1, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R9 add3 mid wrap ok",  3'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0001, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R9 add3 total ovf",    3'd6, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R9 add3 neg ovf",      3'd6, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R9 or no ovf",         3'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);

        // R10: zero flag
        run("R10 sub self zero", 3'd1, 32'h1234_5678, 32'h1234_5678, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R10 and zero",      3'd2, 32'hFF00_FF00, 32'h00FF_00FF, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
        run("R10 add wrap zero", 3'd0, 32'hFFFF_FFFF, 32'd1, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);

        // Sweep every bit-set position and shift count
        for (int i = 0; i < 32; i++) begin
            run("R8 bset sweep", 3'd7, 32'(i) | 32'h5A5A_5A40, 32'h0102_0408, 32'd0, 5'd0, 32'd0, 1'b0, 1'b0);
            run("R6 sra sweep",  3'd5, 32'd0, 32'hB7E1_5163, 32'd0, 5'(i), 32'd0, 1'b0, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule